// File: doc/BRIEF.md
# Dithered PWM Generator

This block produces one pulse-width-modulated output whose period and duty can be set more finely than one clock. The period word and the compare word each hold an integer part in their upper bits and, when dithering is on, a fractional dither count in their low bits. Over a repeating cycle of frames, a chosen subset of frames is made one clock longer, or has its high phase extended by one clock. The average period and the average duty therefore land between whole clock counts.

A two-bit resolution code selects one of four modes: no dithering, a 16-frame cycle, a 32-frame cycle or a 64-frame cycle. New period, compare and resolution values are sampled only in the last clock of a frame. A frame already under way always completes with the settings it started with. The `frame_start_o` strobe marks the first clock of every frame, so surrounding logic can align updates or measurements to frame boundaries.

Top module: `dpwm_gen`

## Requirements
- R1: While `rst_n` is low, `pwm_o` and `frame_start_o` are both 0.
- R2: With `res_i` = 0 there is no dithering. Every frame lasts `period_i`+1 clocks, and `pwm_o` is high for `compare_i` clocks of it.
- R3: With `res_i` = 1, the integer parts are `period_i`>>4 and `compare_i`>>4. Bits [3:0] of each word are its dither count, and the dither pattern repeats every 16 frames.
- R4: With `res_i` = 2, the integer parts are the words shifted right by 5. Bits [4:0] are the dither counts, and the pattern repeats every 32 frames.
- R5: With `res_i` = 3, the integer parts are the words shifted right by 6. Bits [5:0] are the dither counts, and the pattern repeats every 64 frames.
- R6: Frame i of a 2^n-frame cycle is one clock longer when the n-bit reversal of i is below the period dither count. Independently, its compare count is one higher when that reversal is below the compare dither count.
- R7: `pwm_o` is high from the first clock of a frame while the in-frame clock index is below the effective compare count, and low for the rest of the frame. An effective compare at or above the frame length keeps it high for the whole frame; an effective compare of 0 keeps it low.
- R8: `frame_start_o` is high in exactly the first clock of each frame.
- R9: The inputs are sampled only in the last clock of a frame. A change during a frame does not alter that frame.
- R10: When a frame is loaded with a resolution code different from the previous frame's, that frame is index 0 of a new dither cycle.
- R11: Over one full dither cycle, the clock count is 2^n·(P+1)+kp and the high count is 2^n·C+kc. Here P and C are the integer parts and kp and kc are the dither counts, provided every effective compare stays within its frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| period_i | input | VAL_W | Period word: integer part above, dither count in the low bits |
| compare_i | input | VAL_W | Compare word with the same layout as the period word |
| res_i | input | 2 | Resolution code: 0 none, 1 16 frames, 2 32 frames, 3 64 frames |
| pwm_o | output | 1 | PWM waveform |
| frame_start_o | output | 1 | High in the first clock of each frame |

## Verification
Internal reset is released two rising edges after `rst_n` goes high, and the first frame begins at the third edge. The bench's behavioural model starts counting frames at that same edge. From then on, both outputs for each in-frame clock appear one edge after the edge that advanced the counter. Inputs seen at the edge that closes a frame govern the whole next frame. The model therefore steps on every rising edge using the inputs present there, and the outputs are compared at the following falling edge, every cycle. Whole-cycle totals are gathered from the first index-0 frame after a resolution change. They run over exactly 2^n frame strobes and are checked against the closed-form sums.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  // Widest dither field; sets the width of the frame index.
  localparam int IDX_W = 6;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_16   = 2'd1,
    RES_32   = 2'd2,
    RES_64   = 2'd3
  } dith_res_e;

  // Number of low bits that carry the dither count.
  function automatic logic [2:0] dith_bits(dith_res_e r);
    case (r)
      RES_16:  return 3'd4;
      RES_32:  return 3'd5;
      RES_64:  return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dpwm_rst_sync.sv
module dpwm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/dpwm_dither_sel.sv
module dpwm_dither_sel
  import dpwm_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  dith_res_e          res_i,
  input  logic [VAL_W-1:0]   val_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [VAL_W-1:0]   int_o,
  output logic               extra_o
);

  logic [2:0]       nbits;
  logic [IDX_W-1:0] mask;
  logic [IDX_W-1:0] kval;
  logic [IDX_W-1:0] idx_m;
  logic [IDX_W-1:0] rev_full;
  logic [IDX_W-1:0] rev_n;

  always_comb begin
    nbits = dith_bits(res_i);
    mask  = IDX_W'((32'd1 << nbits) - 32'd1);
    kval  = val_i[IDX_W-1:0] & mask;
    idx_m = idx_i & mask;
    int_o = val_i >> nbits;
  end

  // Bit reversal over the full index width, then aligned to n bits.
  for (genvar b = 0; b < IDX_W; b++) begin : g_rev
    assign rev_full[b] = idx_m[IDX_W-1-b];
  end

  always_comb begin
    rev_n   = rev_full >> (3'(IDX_W) - nbits);
    extra_o = (rev_n < kval);
  end

  // R6
  always_comb begin
    extra_only_dith_chk: assert (!(extra_o && (res_i == RES_NONE)))
      else $error("extra clock requested with dithering off");
  end

endmodule

// File: rtl/dpwm_frame_ctr.sv
module dpwm_frame_ctr
  import dpwm_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dith_res_e        res_i,
  input  logic [VAL_W-1:0] per_int_i,
  input  logic             per_extra_i,
  output logic [IDX_W-1:0] idx_nxt_o,
  output logic [VAL_W-1:0] cnt_nxt_o,
  output logic             frame_end_o
);

  logic [VAL_W-1:0] cnt_q, cnt_d;
  logic [VAL_W-1:0] top_q, top_d;
  logic [IDX_W-1:0] fidx_q, fidx_d;
  dith_res_e        res_q, res_d;
  logic             frame_end;

  assign frame_end = (cnt_q == top_q);

  // Index of the frame about to be loaded.
  always_comb begin
    if (res_i != res_q) idx_nxt_o = '0;
    else                idx_nxt_o = fidx_q + 1'b1;
  end

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    top_d  = top_q;
    fidx_d = fidx_q;
    res_d  = res_q;
    if (frame_end) begin
      cnt_d  = '0;
      top_d  = per_int_i + VAL_W'(per_extra_i);
      fidx_d = idx_nxt_o;
      res_d  = res_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      top_q  <= '0;
      fidx_q <= '1;
      res_q  <= RES_NONE;
    end else begin
      cnt_q  <= cnt_d;
      top_q  <= top_d;
      fidx_q <= fidx_d;
      res_q  <= res_d;
    end
  end

  assign cnt_nxt_o   = cnt_d;
  assign frame_end_o = frame_end;

  // R8
  cnt_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= top_q);

  // R8
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (cnt_q == '0));

  // R9
  hold_mid_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(top_q) && $stable(res_q)));

  // R10
  res_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && (res_i != res_q)) |=> (fidx_q == '0));

endmodule

// File: rtl/dpwm_wave.sv
module dpwm_wave #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end_i,
  input  logic [VAL_W-1:0] cnt_nxt_i,
  input  logic [VAL_W-1:0] cmp_int_i,
  input  logic             cmp_extra_i,
  output logic             pwm_o,
  output logic             fs_o
);

  logic [VAL_W-1:0] cmp_q, cmp_d;
  logic             pwm_q, pwm_d;
  logic             fs_q, fs_d;

  always_comb begin
    cmp_d = cmp_q;
    if (frame_end_i) cmp_d = cmp_int_i + VAL_W'(cmp_extra_i);
    pwm_d = (cnt_nxt_i < cmp_d);
    fs_d  = frame_end_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      pwm_q <= 1'b0;
      fs_q  <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      pwm_q <= pwm_d;
      fs_q  <= fs_d;
    end
  end

  assign pwm_o = pwm_q;
  assign fs_o  = fs_q;

  // R7
  first_clk_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> (pwm_q == (cmp_q != '0)));

  // R7
  no_rise_mid_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs_q && !$past(pwm_q)) |-> !pwm_q);

endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen
  import dpwm_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] period_i,
  input  logic [VAL_W-1:0] compare_i,
  input  logic [1:0]       res_i,
  output logic             pwm_o,
  output logic             frame_start_o
);

  localparam int N_SEL = 2;  // 0: period, 1: compare

  logic             srst_n;
  dith_res_e        res_e;
  logic [IDX_W-1:0] idx_nxt;
  logic [VAL_W-1:0] cnt_nxt;
  logic             frame_end;

  logic [N_SEL-1:0][VAL_W-1:0] sel_val;
  logic [N_SEL-1:0][VAL_W-1:0] sel_int;
  logic [N_SEL-1:0]            sel_extra;

  assign res_e      = dith_res_e'(res_i);
  assign sel_val[0] = period_i;
  assign sel_val[1] = compare_i;

  dpwm_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  for (genvar s = 0; s < N_SEL; s++) begin : g_sel
    dpwm_dither_sel #(.VAL_W(VAL_W)) i_sel (
      .res_i   (res_e),
      .val_i   (sel_val[s]),
      .idx_i   (idx_nxt),
      .int_o   (sel_int[s]),
      .extra_o (sel_extra[s])
    );
  end

  dpwm_frame_ctr #(.VAL_W(VAL_W)) i_frame_ctr (
    .clk         (clk),
    .rst_n       (srst_n),
    .res_i       (res_e),
    .per_int_i   (sel_int[0]),
    .per_extra_i (sel_extra[0]),
    .idx_nxt_o   (idx_nxt),
    .cnt_nxt_o   (cnt_nxt),
    .frame_end_o (frame_end)
  );

  dpwm_wave #(.VAL_W(VAL_W)) i_wave (
    .clk         (clk),
    .rst_n       (srst_n),
    .frame_end_i (frame_end),
    .cnt_nxt_i   (cnt_nxt),
    .cmp_int_i   (sel_int[1]),
    .cmp_extra_i (sel_extra[1]),
    .pwm_o       (pwm_o),
    .fs_o        (frame_start_o)
  );

  // R1
  quiet_in_reset_chk: assert property (@(posedge clk)
    !srst_n |-> (!pwm_o && !frame_start_o));

endmodule

// File: tb/test_dpwm_gen.sv
`timescale 1ns/1ps
module test_dpwm_gen;

  localparam int VAL_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [VAL_W-1:0] period_i;
  logic [VAL_W-1:0] compare_i;
  logic [1:0]       res_i;
  logic             pwm_o;
  logic             frame_start_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;  // 250 MHz

  dpwm_gen #(.VAL_W(VAL_W)) i_dpwm_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .period_i      (period_i),
    .compare_i     (compare_i),
    .res_i         (res_i),
    .pwm_o         (pwm_o),
    .frame_start_o (frame_start_o)
  );

  // ---------------- behavioural reference ----------------
  int m_act, m_cnt, m_len, m_hi, m_idx, m_res;
  bit m_started;

  function automatic int nbits_of(int r);
    return (r == 0) ? 0 : r + 3;
  endfunction

  function automatic int bitrev(int v, int nb);
    int r = 0;
    for (int i = 0; i < nb; i++) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0;
      m_started = 0;
      m_res = 0;
    end else if (m_act < 2) begin
      m_act++;
    end else if (!m_started || m_cnt == m_len - 1) begin
      int nb, kp, kc, rv;
      nb = nbits_of(int'(res_i));
      if (!m_started || int'(res_i) != m_res) m_idx = 0;
      else m_idx = (m_idx + 1) % (1 << nb);
      kp = int'(period_i) % (1 << nb);
      kc = int'(compare_i) % (1 << nb);
      rv = bitrev(m_idx, nb);
      m_len = (int'(period_i) >> nb) + 1 + ((rv < kp) ? 1 : 0);
      m_hi  = (int'(compare_i) >> nb) + ((rv < kc) ? 1 : 0);
      m_cnt = 0;
      m_res = int'(res_i);
      m_started = 1;
    end else begin
      m_cnt++;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the rising edge.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      int ep, ef;
      ep = (m_started && m_cnt < m_hi) ? 1 : 0;
      ef = (m_started && m_cnt == 0) ? 1 : 0;
      check({cur_req, "/R7"}, "pwm_o", int'(pwm_o), ep);
      check({cur_req, "/R8"}, "frame_start_o", int'(frame_start_o), ef);
    end
  end

  // Watchdog
  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic set_in(int r, int p, int c);
    @(negedge clk);
    res_i     = 2'(r);
    period_i  = VAL_W'(p);
    compare_i = VAL_W'(c);
  endtask

  task automatic wait_frames(int n);
    for (int f = 0; f < n; f++) begin
      do @(negedge clk); while (!frame_start_o);
    end
  endtask

  // R11: totals over a full dither cycle, from its index-0 frame.
  task automatic measure(string req, int r, int p, int c);
    int nb, nfr, len, hi, frames;
    nb = nbits_of(r);
    nfr = 1 << nb;
    do @(negedge clk); while (!(frame_start_o && m_idx == 0));
    len = 0; hi = 0; frames = 0;
    do begin
      len++;
      hi += int'(pwm_o);
      @(negedge clk);
      if (frame_start_o) frames++;
    end while (frames < nfr);
    check({req, "/R11"}, "cycle clocks", len, nfr * ((p >> nb) + 1) + (p % nfr));
    check({req, "/R11"}, "cycle high clocks", hi, nfr * (c >> nb) + (c % nfr));
  endtask

  initial begin
    rst_n = 1'b0;
    res_i = 2'd0;
    period_i = VAL_W'(9);
    compare_i = VAL_W'(4);
    // R1: outputs quiet under reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1", "pwm_o in reset", int'(pwm_o), 0);
      check("R1", "frame_start_o in reset", int'(frame_start_o), 0);
    end
    rst_n = 1'b1;

    // R2: plain integer period and compare
    cur_req = "R2";
    wait_frames(3);
    measure("R2", 0, 9, 4);
    set_in(0, 5, 0);   wait_frames(3);   // never high
    set_in(0, 4, 20);  wait_frames(3);   // compare beyond frame: always high
    set_in(0, 0, 1);   wait_frames(4);   // one-clock frames

    // R3 / R6 / R10: 16-frame cycle
    cur_req = "R3";
    set_in(1, (7 << 4) | 5, (3 << 4) | 11);
    measure("R3", 1, (7 << 4) | 5, (3 << 4) | 11);

    // R4: 32-frame cycle
    cur_req = "R4";
    set_in(2, (6 << 5) | 17, (2 << 5) | 31);
    measure("R4", 2, (6 << 5) | 17, (2 << 5) | 31);

    // R5: 64-frame cycle
    cur_req = "R5";
    set_in(3, (5 << 6) | 63, (4 << 6) | 1);
    measure("R5", 3, (5 << 6) | 63, (4 << 6) | 1);

    // R6: dithered compare past the dithered period keeps output high
    cur_req = "R6";
    set_in(1, (2 << 4) | 3, (3 << 4) | 15);
    wait_frames(20);

    // R9: change mid-frame; the running frame keeps old settings
    cur_req = "R9";
    set_in(0, 20, 10);
    wait_frames(2);
    for (int i = 0; i < 5; i++) @(negedge clk);
    check("R9", "frame_start_o mid-frame", int'(frame_start_o), 0);
    set_in(0, 3, 1);
    wait_frames(4);

    // R10: resolution switch restarts the cycle at index 0
    cur_req = "R10";
    set_in(2, (3 << 5) | 9, (1 << 5) | 20);
    wait_frames(5);
    set_in(1, (3 << 4) | 9, (1 << 4) | 6);
    measure("R10", 1, (3 << 4) | 9, (1 << 4) | 6);

    for (int i = 0; i < 4; i++) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule